// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers twenty-seven interrupt sources and presents the most urgent one to a processor as a 3-bit active-low priority level, seven levels deep. The sources come in four groups: seven backplane interrupt lines, seven local interrupt lines, five internal error/status conditions and eight interprocessor switches. Every source has its own configuration byte. The byte sets a priority level (0 disables the source), chooses edge or level sensing, sets the active polarity, and says whether this block or the interrupting device supplies the status/ID vector.

The processor answers a request with an acknowledge cycle. It pulses `ackStb` together with the level it is serving. One clock later the block returns `ackDone` with the vector of the winning source. If no source is pending at that level, it flags the cycle as spurious. An acknowledge clears the latched request of an edge-sensed source. Latched requests can also be dropped through a write to the register port.

Source index order: backplane lines 1..7 are indices 0..6, local lines 1..7 are 7..13, status sources are 14..18 (power-fail, system-fail, failed posted write, DMA complete, arbitration timeout), and switches 0..7 are 19..26.

Top module: `irqPrioCtl`

## Requirements
- R1: After reset `iplN` is 3'b111, `ackDone`, `ackNone` and `ackExt` are 0, and every source is disabled (configuration 0, vector 8'h40 plus the source index).
- R2: A write to address 0x00+i (i < 27) sets the configuration of source i. Bits [2:0] hold the level, bit 3 selects edge mode (1) or level mode (0), bit 4 is the polarity (1 = active high / rising edge, 0 = active low / falling edge), and bit 5 selects an internally supplied vector (1).
- R3: A level-sensed source requests while its input sits at the active polarity. `iplN` follows the input one clock after the input changes.
- R4: An edge-sensed source latches on the configured edge (rising or falling). The latch holds after the input returns, and `iplN` reflects the edge one clock after it.
- R5: `iplN` is the bitwise inverse of the highest level among the requesting sources, and 3'b111 when none requests.
- R6: A source configured with level 0 never affects `iplN` and is never selected by an acknowledge.
- R7: One clock after `ackStb` with level L, `ackDone` pulses. The lowest-indexed source requesting at level L is served, and `ackVec` is its vector register (address 0x20+i) when bit 5 of its configuration is set.
- R8: When the served source has bit 5 clear, `ackExt` is 1 and `ackVec` is 8'h00.
- R9: When no source requests at the acknowledged level, `ackNone` is 1, `ackExt` is 0 and `ackVec` is the spurious vector 8'h0F.
- R10: An acknowledge clears the latch of the served edge source only. Other latched sources at the same level stay pending.
- R11: A write of index i to address 0x40 clears the latched edge request of source i.
- R12: All four source groups map onto the indices given above, so each input bit drives the source its group and position name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 7 | Register address |
| regWdata | input | 8 | Register write data |
| bpIrq | input | 7 | Backplane interrupt lines 1..7 |
| locIrq | input | 7 | Local interrupt lines 1..7 |
| statIrq | input | 5 | Internal error/status conditions |
| swIrq | input | 8 | Interprocessor switch requests |
| ackStb | input | 1 | Acknowledge strobe, one clock |
| ackLvl | input | 3 | Level being acknowledged |
| iplN | output | 3 | Active-low encoded priority level |
| ackDone | output | 1 | Acknowledge result valid |
| ackVec | output | 8 | Status/ID vector |
| ackExt | output | 1 | Vector must come from the device |
| ackNone | output | 1 | Spurious acknowledge |

## Verification
The assertions assume that all interrupt inputs are already synchronous to `clk` and that `ackStb` is a single-clock pulse that is never repeated in the cycle when its result appears. The bench changes inputs only on the falling edge and spaces every acknowledge so that each result is read before the next strobe. Edge sources are driven with single-clock pulses that never coincide with an acknowledge of the same source.

// File: rtl/irqPrioPkg.sv
package irqPrioPkg;
  localparam int NUM_BP   = 7;
  localparam int NUM_LOC  = 7;
  localparam int NUM_STAT = 5;
  localparam int NUM_SW   = 8;
  localparam int NUM_SRC  = NUM_BP + NUM_LOC + NUM_STAT + NUM_SW;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int LVL_W    = 3;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int CFG_W    = 6;
  // configuration byte fields
  localparam int CFG_EDGE = 3;
  localparam int CFG_POL  = 4;
  localparam int CFG_INT  = 5;
  localparam logic [1:0] CFG_PAGE = 2'b00;
  localparam logic [1:0] VEC_PAGE = 2'b01;
  localparam logic [ADDR_W-1:0] CLR_ADDR = 7'h40;

  typedef logic [IDX_W-1:0] srcIdx_t;
  typedef struct packed {
    logic    clr;
    srcIdx_t idx;
  } ctrlStb_t;
endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPrioPkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE = 8'h40
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWe,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic [DATA_W-1:0]                regWdata,
  input  logic [NUM_SRC-1:0]               rawIrq,
  input  ctrlStb_t                         ctrl,
  output logic [NUM_SRC-1:0]               req,
  output logic [NUM_SRC-1:0][LVL_W-1:0]    lvl,
  output logic [DATA_W-1:0]                selVec,
  output logic                             selInt
);
  logic [NUM_SRC-1:0][CFG_W-1:0]  cfgReg;
  logic [NUM_SRC-1:0][DATA_W-1:0] vecReg;
  logic [NUM_SRC-1:0]             prevIn;
  logic [NUM_SRC-1:0]             latchQ;

  logic inRange;
  assign inRange = regAddr[IDX_W-1:0] < IDX_W'(NUM_SRC);

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    logic cfgHit, vecHit, wrClr, ackClr, edgeSeen, edgeMode, pol;

    assign cfgHit   = regWe && regAddr[ADDR_W-1:ADDR_W-2] == CFG_PAGE
                      && regAddr[IDX_W-1:0] == IDX_W'(i) && inRange;
    assign vecHit   = regWe && regAddr[ADDR_W-1:ADDR_W-2] == VEC_PAGE
                      && regAddr[IDX_W-1:0] == IDX_W'(i) && inRange;
    assign wrClr    = regWe && regAddr == CLR_ADDR
                      && regWdata[IDX_W-1:0] == IDX_W'(i);
    assign ackClr   = ctrl.clr && ctrl.idx == IDX_W'(i);
    assign edgeMode = cfgReg[i][CFG_EDGE];
    assign pol      = cfgReg[i][CFG_POL];
    assign edgeSeen = pol ? (rawIrq[i] & ~prevIn[i]) : (~rawIrq[i] & prevIn[i]);
    assign lvl[i]   = cfgReg[i][LVL_W-1:0];

    always_comb begin
      if (edgeMode) req[i] = latchQ[i] | edgeSeen;
      else          req[i] = (rawIrq[i] == pol);
      if (lvl[i] == '0) req[i] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgReg[i] <= '0;
        vecReg[i] <= VEC_BASE + DATA_W'(i);
        prevIn[i] <= 1'b0;
        latchQ[i] <= 1'b0;
      end else begin
        prevIn[i] <= rawIrq[i];
        if (cfgHit) cfgReg[i] <= regWdata[CFG_W-1:0];
        if (vecHit) vecReg[i] <= regWdata;
        if (!edgeMode)        latchQ[i] <= 1'b0;
        else if (edgeSeen)    latchQ[i] <= 1'b1;
        else if (ackClr || wrClr) latchQ[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    selVec = '0;
    selInt = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (ctrl.idx == IDX_W'(i)) begin
        selVec = vecReg[i];
        selInt = cfgReg[i][CFG_INT];
      end
    end
  end
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPrioPkg::*;
#(
  parameter logic [DATA_W-1:0] SPUR_VEC = 8'h0F
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            req,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
  input  logic                          ackStb,
  input  logic [LVL_W-1:0]              ackLvl,
  input  logic [DATA_W-1:0]             selVec,
  input  logic                          selInt,
  output ctrlStb_t                      ctrl,
  output logic [LVL_W-1:0]              iplN,
  output logic                          ackDone,
  output logic [DATA_W-1:0]             ackVec,
  output logic                          ackExt,
  output logic                          ackNone
);
  logic [LVL_W-1:0] maxLvl;
  logic             found;
  srcIdx_t          selIdx;

  always_comb begin
    maxLvl = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (req[i] && lvl[i] > maxLvl) maxLvl = lvl[i];
  end

  // descending scan so the lowest index wins
  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i] && lvl[i] == ackLvl) begin
        found  = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  assign ctrl.clr = ackStb && found;
  assign ctrl.idx = selIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iplN    <= '1;
      ackDone <= 1'b0;
      ackVec  <= '0;
      ackExt  <= 1'b0;
      ackNone <= 1'b0;
    end else begin
      iplN    <= ~maxLvl;
      ackDone <= ackStb;
      ackNone <= ackStb && !found;
      ackExt  <= ackStb && found && !selInt;
      if (ackStb) begin
        if (!found)      ackVec <= SPUR_VEC;
        else if (selInt) ackVec <= selVec;
        else             ackVec <= '0;
      end
    end
  end
endmodule

// File: rtl/irqPrioCtl.sv
module irqPrioCtl
  import irqPrioPkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE = 8'h40,
  parameter logic [DATA_W-1:0] SPUR_VEC = 8'h0F
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  input  logic [NUM_BP-1:0]     bpIrq,
  input  logic [NUM_LOC-1:0]    locIrq,
  input  logic [NUM_STAT-1:0]   statIrq,
  input  logic [NUM_SW-1:0]     swIrq,
  input  logic                  ackStb,
  input  logic [LVL_W-1:0]      ackLvl,
  output logic [LVL_W-1:0]      iplN,
  output logic                  ackDone,
  output logic [DATA_W-1:0]     ackVec,
  output logic                  ackExt,
  output logic                  ackNone
);
  logic [NUM_SRC-1:0]            rawIrq;
  logic [NUM_SRC-1:0]            req;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic [DATA_W-1:0]             selVec;
  logic                          selInt;
  ctrlStb_t                      ctrl;

  // R12: group placement, index 0 upward
  assign rawIrq = {swIrq, statIrq, locIrq, bpIrq};

  irqDatapath #(.VEC_BASE(VEC_BASE)) uDp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .rawIrq(rawIrq), .ctrl(ctrl), .req(req),
    .lvl(lvl), .selVec(selVec), .selInt(selInt)
  );

  irqControl #(.SPUR_VEC(SPUR_VEC)) uCtl (
    .clk(clk), .rstN(rstN), .req(req), .lvl(lvl), .ackStb(ackStb),
    .ackLvl(ackLvl), .selVec(selVec), .selInt(selInt), .ctrl(ctrl),
    .iplN(iplN), .ackDone(ackDone), .ackVec(ackVec), .ackExt(ackExt),
    .ackNone(ackNone)
  );
endmodule

// File: rtl/irqPrioChecker.sv
module irqPrioChecker (
  input logic       clk,
  input logic       rstN,
  input logic       ackStb,
  input logic [2:0] ackLvl,
  input logic       ackDone,
  input logic [7:0] ackVec,
  input logic       ackExt,
  input logic       ackNone
);
  a_r7_done_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |=> ackDone);
  a_r7_no_stray_done: assert property (@(posedge clk) disable iff (!rstN)
    !ackStb |=> !ackDone);
  a_r8_external_zero_vec: assert property (@(posedge clk) disable iff (!rstN)
    (ackDone && ackExt) |-> ackVec == 8'h00);
  a_r9_spurious_shape: assert property (@(posedge clk) disable iff (!rstN)
    ackNone |-> (ackDone && !ackExt && ackVec == 8'h0F));
  a_r6_level_zero_never_served: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && ackLvl == 3'd0) |=> ackNone);
endmodule

bind irqPrioCtl irqPrioChecker uChk (
  .clk(clk), .rstN(rstN), .ackStb(ackStb), .ackLvl(ackLvl),
  .ackDone(ackDone), .ackVec(ackVec), .ackExt(ackExt), .ackNone(ackNone)
);

// File: tb/tb_irqPrioCtl.sv
module tb_irqPrioCtl;
  logic       clk = 0;
  logic       rstN = 0;
  logic       regWe = 0;
  logic [6:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [6:0] bpIrq = 7'h7F;
  logic [6:0] locIrq = '0;
  logic [4:0] statIrq = '0;
  logic [7:0] swIrq = '0;
  logic       ackStb = 0;
  logic [2:0] ackLvl = '0;
  logic [2:0] iplN;
  logic       ackDone, ackExt, ackNone;
  logic [7:0] ackVec;
  int nChk = 0, nBad = 0;

  always #10 clk = ~clk;

  irqPrioCtl dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic ack(input logic [2:0] l);
    ackStb = 1; ackLvl = l;
    @(negedge clk);
    ackStb = 0;
  endtask

  task automatic tReset;
    chk("R1 iplN", iplN, 7);
    chk("R1 ackDone", ackDone, 0);
    chk("R1 ackNone", ackNone, 0);
    bpIrq[0] = 0; @(negedge clk);
    chk("R1 disabled after reset", iplN, 7);
    bpIrq[0] = 1; @(negedge clk);
  endtask

  task automatic tLevel;
    wr(7'h08, 8'h33);            // R2 local line 2: lvl3 level high internal
    locIrq[1] = 1; @(negedge clk);
    chk("R3 level high follows", iplN, 4);
    locIrq[1] = 0; @(negedge clk);
    chk("R3 level release", iplN, 7);
    wr(7'h00, 8'h22);            // backplane line 1: lvl2 active low
    bpIrq[0] = 0; @(negedge clk);
    chk("R3 active low", iplN, 5);
    locIrq[1] = 1; @(negedge clk);
    chk("R5 higher level wins", iplN, 4);
    locIrq[1] = 0; @(negedge clk);
    chk("R5 back to lower", iplN, 5);
    bpIrq[0] = 1; @(negedge clk);
    wr(7'h00, 8'h00); wr(7'h08, 8'h00);
  endtask

  task automatic tEdge;
    wr(7'h0E, 8'h3D);            // power-fail: lvl5 rising edge internal
    statIrq[0] = 1; @(negedge clk);
    chk("R4 rising edge seen", iplN, 2);
    statIrq[0] = 0; @(negedge clk);
    chk("R4 latch holds", iplN, 2);
    ack(5);
    chk("R7 done", ackDone, 1);
    chk("R7 vector reset value", ackVec, 8'h4E);
    chk("R7 internal", ackExt, 0);
    @(negedge clk);
    chk("R10 latch cleared by ack", iplN, 7);
    wr(7'h0E, 8'h00);
    wr(7'h0B, 8'h2F);            // local line 5: lvl7 falling edge
    locIrq[4] = 1; @(negedge clk);
    chk("R4 rising ignored in falling mode", iplN, 7);
    locIrq[4] = 0; @(negedge clk);
    chk("R4 falling edge seen", iplN, 0);
    ack(7);
    chk("R4 falling vector", ackVec, 8'h4B);
    @(negedge clk);
    wr(7'h0B, 8'h00);
  endtask

  task automatic tClear;
    wr(7'h16, 8'h3C);            // switch 3: lvl4 rising edge
    swIrq[3] = 1; @(negedge clk);
    swIrq[3] = 0; @(negedge clk);
    chk("R11 pending before clear", iplN, 3);
    wr(7'h40, 8'd22);
    @(negedge clk);
    chk("R11 cleared by write", iplN, 7);
    wr(7'h16, 8'h00);
  endtask

  task automatic tDisabled;
    wr(7'h09, 8'h30);            // local line 3: level 0
    locIrq[2] = 1; @(negedge clk);
    chk("R6 iplN untouched", iplN, 7);
    ack(0);
    chk("R6 not served", ackNone, 1);
    locIrq[2] = 0; @(negedge clk);
  endtask

  task automatic tOrder;
    wr(7'h01, 8'h26);            // backplane line 2: lvl6 active low
    wr(7'h13, 8'h36);            // switch 0: lvl6 active high
    wr(7'h33, 8'hA5);            // switch 0 vector
    bpIrq[1] = 0; swIrq[0] = 1; @(negedge clk);
    chk("R5 level six", iplN, 1);
    ack(6);
    chk("R7 lowest index served", ackVec, 8'h41);
    chk("R12 backplane index", ackNone, 0);
    bpIrq[1] = 1; @(negedge clk);
    ack(6);
    chk("R12 switch programmed vector", ackVec, 8'hA5);
    swIrq[0] = 0; @(negedge clk);
    wr(7'h01, 8'h00); wr(7'h13, 8'h00);
  endtask

  task automatic tExternal;
    wr(7'h0A, 8'h11);            // local line 4: lvl1 high, external
    locIrq[3] = 1; @(negedge clk);
    ack(1);
    chk("R8 ackExt", ackExt, 1);
    chk("R8 vector zero", ackVec, 0);
    locIrq[3] = 0; @(negedge clk);
    wr(7'h0A, 8'h00);
  endtask

  task automatic tSpurious;
    ack(7);
    chk("R9 none", ackNone, 1);
    chk("R9 vector", ackVec, 8'h0F);
    chk("R9 ext low", ackExt, 0);
  endtask

  task automatic tTwoEdges;
    wr(7'h14, 8'h3C); wr(7'h15, 8'h3C);   // switches 1,2: lvl4 rising
    swIrq[2:1] = 2'b11; @(negedge clk);
    swIrq[2:1] = 2'b00; @(negedge clk);
    ack(4);
    chk("R10 first served", ackVec, 8'h54);
    @(negedge clk);
    chk("R10 other still pending", iplN, 3);
    ack(4);
    chk("R10 second served", ackVec, 8'h55);
    @(negedge clk);
    chk("R10 all clear", iplN, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset; tLevel; tEdge; tClear; tDisabled;
    tOrder; tExternal; tSpurious; tTwoEdges;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule